// File: doc/BRIEF.md
# Segmented Data Address Unit

This block generates data-memory addresses for a small 8-bit processor core. Each cycle it picks an 8-bit effective address from one of four sources: an address carried by the instruction, one of two general RAM pointers, or the stack pointer. It then turns that address into a 16-bit physical RAM address.

The 8-bit space is split in two halves. An address in the lower half (bit 7 clear) is banked by an 8-bit segment register into one of 256 segments of 128 bytes each. An address in the upper half (bit 7 set) always lands in physical page zero. This keeps the 16-byte register window at 0xF0–0xFF reachable from every segment, and the pointer registers themselves live in that window.

When an access goes through a pointer, that pointer can be incremented or decremented after use. The access itself always uses the value the pointer held before the change. The instruction decoder, the RAM array and the ALU sit outside this block. They drive the mode inputs, and they use the register port to read and write the four address registers at their fixed window addresses.

Top module: `seg_addr_unit`

## Requirements
- R1: When effective address bit 7 is 0, `phys_addr_o` equals {segment register, 1'b0, effective address bits 6:0}. For example, segment 1 with effective address 0x00 gives 0x0100, and with 0x7F gives 0x017F.
- R2: When effective address bit 7 is 1, `phys_addr_o` equals {8'h00, effective address}, whatever the segment register holds.
- R3: `win_hit_o` is 1 exactly when the effective address lies in 0xF0–0xFF. Such an address is always translated unextended, into physical 0x00F0–0x00FF.
- R4: The register port maps four addresses to the address registers: 0xFC to pointer B, 0xFD to the stack pointer, 0xFE to pointer A and 0xFF to the segment register.
  - `rd_data_o` combinationally returns the addressed register, or 0x00 for any other address.
  - A write with `wr_en_i`=1 loads `wr_data_i` into the addressed register at the next clock edge.
  - A write to any other address changes no register.
- R5: `src_i` selects the effective address: 0 = `direct_addr_i`, 1 = pointer A, 2 = pointer B, 3 = stack pointer.
- R6: On a cycle with `acc_i`=1 and `src_i` naming pointer A or pointer B, `mod_i`=1 increments that pointer and `mod_i`=2 decrements it, at the clock edge. The access in that cycle uses the value from before the change. `mod_i`=0 and `mod_i`=3 leave it unchanged.
- R7: Post-modify wraps modulo 256 (0xFF+1 gives 0x00, 0x00-1 gives 0xFF) and never changes the segment register.
- R8: After reset, the stack pointer reads 0x6F and pointer A, pointer B and the segment register read 0x00.
- R9: If the register port writes a pointer in the same cycle as that pointer's post-modify, the pointer takes the written value.
- R10: `mod_i` has no effect when `src_i` is 0 or 3, or when `acc_i`=0. The stack pointer is never post-modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 1 | A data access occurs this cycle (enables post-modify) |
| src_i | input | 2 | Effective address source select |
| mod_i | input | 2 | Pointer post-modify: 0 none, 1 increment, 2 decrement, 3 none |
| direct_addr_i | input | 8 | Address carried by the instruction |
| wr_en_i | input | 1 | Register port write enable |
| wr_addr_i | input | 8 | Register port write address |
| wr_data_i | input | 8 | Register port write data |
| rd_addr_i | input | 8 | Register port read address |
| rd_data_o | output | 8 | Register port read data |
| eff_addr_o | output | 8 | Selected effective address |
| phys_addr_o | output | 16 | Physical RAM address |
| win_hit_o | output | 1 | Effective address is in the 0xF0–0xFF register window |

## Verification
The bench targets the following corners, each with the failure it would expose:
- **Half boundary.** Effective addresses 0x7F and 0x80 under a non-zero segment. A design that tests the wrong bit would either bank the upper half or leave a lower-half address flat.
- **Pointer wrap.** Increment from 0xFF and decrement from 0x00. A design that carries into the segment register, or that wraps at the wrong width, would change the segment or give the wrong pointer value.
- **Explicit write against post-modify.** A write to a pointer in the same cycle as its post-modify. A design with the wrong priority would hold the modified value instead of the written one.
- **Stack and direct accesses.** Accesses with `mod_i` set while the source is the stack pointer or the instruction address. A design with this bug would silently move a pointer it should not touch.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  typedef enum logic [1:0] {
    SRC_DIR = 2'd0,
    SRC_PA  = 2'd1,
    SRC_PB  = 2'd2,
    SRC_STK = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    PM_NONE = 2'd0,
    PM_INC  = 2'd1,
    PM_DEC  = 2'd2,
    PM_RSV  = 2'd3
  } pm_e;
endpackage

// File: rtl/seg_addr_ptr.sv
module seg_addr_ptr #(
  parameter int unsigned W      = 8,
  parameter logic [W-1:0] RST_V = '0,
  parameter bit          MOD_EN = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         step_i,
  input  logic [1:0]   mod_i,
  output logic [W-1:0] q_o
);
  import seg_addr_pkg::*;

  logic [W-1:0] q_q, q_d;
  logic [W-1:0] mod_val;
  logic         mod_act;

  generate
    if (MOD_EN) begin : g_mod
      always_comb begin
        mod_act = 1'b0;
        mod_val = q_q;
        if (step_i) begin
          unique case (pm_e'(mod_i))
            PM_INC:  begin mod_act = 1'b1; mod_val = q_q + W'(1); end
            PM_DEC:  begin mod_act = 1'b1; mod_val = q_q - W'(1); end
            default: ;
          endcase
        end
      end
    end else begin : g_nomod
      logic unused_mod;
      assign unused_mod = ^{step_i, mod_i};
      assign mod_act = 1'b0;
      assign mod_val = q_q;
    end
  endgenerate

  // explicit write has priority over post-modify
  always_comb begin
    q_d = q_q;
    if (wr_i)         q_d = wr_data_i;
    else if (mod_act) q_d = mod_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= RST_V;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  // R9
  wr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> q_o == $past(wr_data_i));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !(MOD_EN && step_i && (mod_i == 2'd1 || mod_i == 2'd2))) |=> $stable(q_o));

  generate
    if (MOD_EN) begin : g_mod_chk
      // R6
      post_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_i && step_i && mod_i == 2'd1) |=> q_o == $past(q_o) + W'(1));
      // R7
      post_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_i && step_i && mod_i == 2'd2) |=> q_o == $past(q_o) - W'(1));
    end
  endgenerate
endmodule

// File: rtl/seg_addr_map.sv
module seg_addr_map #(
  parameter int unsigned AW = 8,
  parameter int unsigned SW = 8,
  parameter logic [AW-1:0] PB_ADDR  = 8'hFC,
  parameter logic [AW-1:0] STK_ADDR = 8'hFD,
  parameter logic [AW-1:0] PA_ADDR  = 8'hFE,
  parameter logic [AW-1:0] SEG_ADDR = 8'hFF
) (
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [AW-1:0] pa_i,
  input  logic [AW-1:0] pb_i,
  input  logic [AW-1:0] stk_i,
  input  logic [SW-1:0] seg_i,
  output logic [3:0]    wr_sel_o,
  output logic [AW-1:0] rd_data_o
);
  localparam int unsigned NREG = 4;
  localparam logic [NREG*AW-1:0] MAP = {SEG_ADDR, PA_ADDR, STK_ADDR, PB_ADDR};

  logic [NREG*AW-1:0] vals;
  assign vals = {AW'(seg_i), pa_i, stk_i, pb_i};

  // slot order: 0 pb, 1 stk, 2 pa, 3 seg
  generate
    for (genvar i = 0; i < NREG; i++) begin : g_wsel
      assign wr_sel_o[i] = wr_en_i && (wr_addr_i == MAP[i*AW +: AW]);
    end
  endgenerate

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr_i == MAP[i*AW +: AW]) rd_data_o = vals[i*AW +: AW];
  end

  // R4
  wsel_onehot_chk: assert final ($onehot0(wr_sel_o) || $isunknown(wr_sel_o));
endmodule

// File: rtl/seg_addr_xlate.sv
module seg_addr_xlate #(
  parameter int unsigned AW = 8,
  parameter int unsigned SW = 8,
  parameter int unsigned PW = SW + AW
) (
  input  logic [AW-1:0] ea_i,
  input  logic [SW-1:0] seg_i,
  output logic [PW-1:0] phys_o
);
  always_comb begin
    if (ea_i[AW-1]) phys_o = {{SW{1'b0}}, ea_i};
    else            phys_o = {seg_i, 1'b0, ea_i[AW-2:0]};
  end
endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit #(
  parameter int unsigned AW = 8,
  parameter int unsigned SW = 8,
  parameter logic [AW-1:0] PB_ADDR  = 8'hFC,
  parameter logic [AW-1:0] STK_ADDR = 8'hFD,
  parameter logic [AW-1:0] PA_ADDR  = 8'hFE,
  parameter logic [AW-1:0] SEG_ADDR = 8'hFF,
  parameter logic [AW-1:0] STK_RST  = 8'h6F,
  parameter logic [AW-1:0] WIN_BASE = 8'hF0,
  parameter int unsigned   WIN_LOG  = 4,
  localparam int unsigned  PW = SW + AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic [1:0]    src_i,
  input  logic [1:0]    mod_i,
  input  logic [AW-1:0] direct_addr_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [AW-1:0] rd_data_o,
  output logic [AW-1:0] eff_addr_o,
  output logic [PW-1:0] phys_addr_o,
  output logic          win_hit_o
);
  import seg_addr_pkg::*;

  logic [AW-1:0] pa_q, pb_q, stk_q;
  logic [SW-1:0] seg_q;
  logic [3:0]    wr_sel;
  src_e          src;

  assign src = src_e'(src_i);

  seg_addr_map #(
    .AW(AW), .SW(SW), .PB_ADDR(PB_ADDR), .STK_ADDR(STK_ADDR),
    .PA_ADDR(PA_ADDR), .SEG_ADDR(SEG_ADDR)
  ) u_map (
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .rd_addr_i(rd_addr_i),
    .pa_i(pa_q), .pb_i(pb_q), .stk_i(stk_q), .seg_i(seg_q),
    .wr_sel_o(wr_sel), .rd_data_o(rd_data_o)
  );

  seg_addr_ptr #(.W(AW), .RST_V('0), .MOD_EN(1'b1)) u_pb (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_sel[0]), .wr_data_i(wr_data_i),
    .step_i(acc_i && src == SRC_PB), .mod_i(mod_i), .q_o(pb_q)
  );

  seg_addr_ptr #(.W(AW), .RST_V(STK_RST), .MOD_EN(1'b0)) u_stk (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_sel[1]), .wr_data_i(wr_data_i),
    .step_i(1'b0), .mod_i(2'd0), .q_o(stk_q)
  );

  seg_addr_ptr #(.W(AW), .RST_V('0), .MOD_EN(1'b1)) u_pa (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_sel[2]), .wr_data_i(wr_data_i),
    .step_i(acc_i && src == SRC_PA), .mod_i(mod_i), .q_o(pa_q)
  );

  seg_addr_ptr #(.W(SW), .RST_V('0), .MOD_EN(1'b0)) u_seg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_sel[3]), .wr_data_i(SW'(wr_data_i)),
    .step_i(1'b0), .mod_i(2'd0), .q_o(seg_q)
  );

  always_comb begin
    unique case (src)
      SRC_PA:  eff_addr_o = pa_q;
      SRC_PB:  eff_addr_o = pb_q;
      SRC_STK: eff_addr_o = stk_q;
      default: eff_addr_o = direct_addr_i;
    endcase
  end

  localparam logic [AW-1:0] WIN = WIN_BASE;
  assign win_hit_o = (eff_addr_o[AW-1:WIN_LOG] == WIN[AW-1:WIN_LOG]);

  seg_addr_xlate #(.AW(AW), .SW(SW), .PW(PW)) u_xlate (
    .ea_i(eff_addr_o), .seg_i(seg_q), .phys_o(phys_addr_o)
  );

  // R1
  lower_seg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eff_addr_o[AW-1] |-> (phys_addr_o[PW-1:AW] == seg_q && !phys_addr_o[AW-1]));
  // R2
  upper_flat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff_addr_o[AW-1] |-> phys_addr_o[PW-1:AW] == '0);
  // R3
  window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_hit_o |-> (phys_addr_o >> WIN_LOG) == (PW'(WIN_BASE) >> WIN_LOG));
  // R7
  seg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i == SEG_ADDR) |=> $stable(seg_q));
endmodule

// File: tb/seg_addr_unit_test.sv
module seg_addr_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc = 1'b0;
  logic [1:0]  src = '0, mod = '0;
  logic [7:0]  da = '0, wa = '0, wd = '0, ra = '0;
  logic        we = 1'b0;
  logic [7:0]  rd, eff;
  logic [15:0] phys;
  logic        win;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] m_pa, m_pb, m_stk, m_seg;

  always #2.5 clk = ~clk;

  seg_addr_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .acc_i(acc), .src_i(src), .mod_i(mod),
    .direct_addr_i(da), .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .rd_addr_i(ra), .rd_data_o(rd), .eff_addr_o(eff), .phys_addr_o(phys),
    .win_hit_o(win)
  );

  function automatic logic [15:0] exp_phys(logic [7:0] ea, logic [7:0] sg);
    return ea[7] ? {8'h00, ea} : {sg, 1'b0, ea[6:0]};
  endfunction

  function automatic logic [7:0] exp_eff(logic [1:0] s, logic [7:0] d);
    case (s)
      2'd1: return m_pa;
      2'd2: return m_pb;
      2'd3: return m_stk;
      default: return d;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(logic [7:0] a);
    case (a)
      8'hFC: return m_pb;
      8'hFD: return m_stk;
      8'hFE: return m_pa;
      8'hFF: return m_seg;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit a, logic [1:0] s, logic [1:0] m, logic [7:0] d,
                      bit w, logic [7:0] waddr, logic [7:0] wdata,
                      logic [7:0] raddr, string rtag);
    logic [7:0] e;
    @(negedge clk);
    acc = a; src = s; mod = m; da = d; we = w; wa = waddr; wd = wdata; ra = raddr;
    #1;
    e = exp_eff(s, d);
    chk(eff === e, "R5", {8'h0, eff}, {8'h0, e});
    chk(phys === exp_phys(e, m_seg), e[7] ? "R2" : "R1", phys, exp_phys(e, m_seg));
    chk(win === (e[7:4] == 4'hF), "R3", {15'h0, win}, {15'h0, e[7:4] == 4'hF});
    chk(rd === exp_rd(raddr), rtag, {8'h0, rd}, {8'h0, exp_rd(raddr)});
    @(posedge clk);
    if (a && (m == 2'd1 || m == 2'd2)) begin
      if (s == 2'd1) m_pa = (m == 2'd1) ? m_pa + 8'd1 : m_pa - 8'd1;
      if (s == 2'd2) m_pb = (m == 2'd1) ? m_pb + 8'd1 : m_pb - 8'd1;
    end
    if (w) case (waddr)
      8'hFC: m_pb = wdata;
      8'hFD: m_stk = wdata;
      8'hFE: m_pa = wdata;
      8'hFF: m_seg = wdata;
      default: ;
    endcase
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    step(0, 0, 0, 8'h00, 1, a, d, 8'h00, "R4");
  endtask

  task automatic rdchk(logic [7:0] a, string tag);
    step(0, 0, 0, 8'h00, 0, 8'h00, 8'h00, a, tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_pa = 8'h00; m_pb = 8'h00; m_stk = 8'h6F; m_seg = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset values
    rdchk(8'hFD, "R8"); rdchk(8'hFC, "R8"); rdchk(8'hFE, "R8"); rdchk(8'hFF, "R8");
    // R1 / R2 half boundary under segment 1
    wr(8'hFF, 8'h01);
    step(0, 0, 0, 8'h00, 0, 0, 0, 8'hFF, "R4");
    step(0, 0, 0, 8'h7F, 0, 0, 0, 8'hFF, "R1");
    step(0, 0, 0, 8'h80, 0, 0, 0, 8'hFF, "R2");
    step(0, 0, 0, 8'hF3, 0, 0, 0, 8'hFF, "R3");
    // R4 unmapped write ignored
    wr(8'hFB, 8'h55);
    rdchk(8'hFB, "R4"); rdchk(8'hFC, "R4"); rdchk(8'hFE, "R4");
    // R6 / R7 wrap, seg untouched
    wr(8'hFE, 8'hFF);
    step(1, 1, 1, 8'h00, 0, 0, 0, 8'hFE, "R6");
    rdchk(8'hFE, "R7"); rdchk(8'hFF, "R7");
    step(1, 2, 2, 8'h00, 0, 0, 0, 8'hFC, "R6");
    rdchk(8'hFC, "R7"); rdchk(8'hFF, "R7");
    // R6 mod 3 no change
    step(1, 2, 3, 8'h00, 0, 0, 0, 8'hFC, "R6");
    rdchk(8'hFC, "R6");
    // R9 write wins over post-modify
    step(1, 1, 1, 8'h00, 1, 8'hFE, 8'h40, 8'hFE, "R9");
    rdchk(8'hFE, "R9");
    // R10 stack / direct / no-access ignore mod
    step(1, 3, 1, 8'h00, 0, 0, 0, 8'hFD, "R10");
    rdchk(8'hFD, "R10");
    step(1, 0, 2, 8'h12, 0, 0, 0, 8'hFE, "R10");
    rdchk(8'hFE, "R10"); rdchk(8'hFC, "R10");
    step(0, 1, 1, 8'h00, 0, 0, 0, 8'hFE, "R10");
    rdchk(8'hFE, "R10");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] wa_r, ra_r;
      wa_r = ($urandom % 4 != 0) ? (8'hFC + 8'($urandom % 4)) : 8'($urandom);
      ra_r = ($urandom % 4 != 0) ? (8'hFC + 8'($urandom % 4)) : 8'($urandom);
      step(1'($urandom), 2'($urandom), 2'($urandom), 8'($urandom),
           ($urandom % 5 == 0), wa_r, 8'($urandom), ra_r, "R4");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule